// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is a management-interface master that issues single Clause-22 MDIO read or write frames to an external PHY. Software reaches it through two 32-bit registers on a simple memory-mapped bus. One register holds the PHY address. The other register does several jobs at once. Writing it with its go bit set launches a frame. The same register reports while the frame is in flight. After a read frame ends, it holds the 16-bit value that came back.

The block runs from a 25 MHz reference clock and divides it down to MDC by one of eight selectable ratios. MDC has a 50 percent duty cycle and sits low between frames. MDIO is driven through a data output with an output enable, so an external pad can tristate it. The incoming MDIO line is sampled when MDC rises. The 32-bit preamble can be left out of a frame. Three mode bits are only stored and read back.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, both registers read zero, MDC is low and the MDIO output enable is low.
- R2: The PHY-address register (offset 0x1418) keeps written bits 20:16 and reads zero in every other bit. Any offset other than 0x1414 or 0x1418 reads zero.
- R3: Writing the control register (offset 0x1414) with bit 23 set launches a frame. From the next cycle, bit 23 and bit 27 both read 1. Both return to 0 once the frame has ended.
- R4: The clock-select field (bits 26:24, values 0 to 7) sets the MDC period to 4, 6, 8, 10, 14, 20, 24 or 28 reference clocks. MDC is high for exactly half of that period and is low whenever no frame is active.
- R5: A write frame (bit 21 = 0) sends the following, most significant bit first:
  - 32 ones
  - 01
  - 01
  - the 5-bit PHY address
  - the 5-bit register address from bits 20:16
  - 10
  - the 16 data bits from bits 15:0 of the launching write

  Each bit is driven with the output enable high. MDIO changes only while MDC is low.
- R6: With bit 22 set, the preamble is omitted. The frame has 32 MDC cycles and starts directly with 01.
- R7: A read frame (bit 21 = 1) sends the opcode 10. The output enable is low from the first turnaround bit through the last data bit. MDIO is sampled on each rising MDC edge of the 16 data bits. The sampled word reads back in bits 15:0 once bits 23 and 27 are clear.
- R8: While a frame is active, a control-register write changes only bits 30:28. It launches nothing and leaves the clock select, data and other fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
The bench runs four frames, and each one separates a different pair of behaviours:
- A write frame with the preamble at the fastest divider checks the opcode, the bit order and the turnaround driving. It also shows that MDC runs at a quarter of the reference clock.
- A read frame at a middle divider checks the released turnaround and the sampling edge. It uses an asymmetric PHY word, so a bit-order or off-by-one sampling fault changes the read-back value.
- A read frame without the preamble returns a word whose only set bits are the first and last. This exposes a shift that drops either end of the word, and it checks the 32-cycle frame length.
- A write frame at the slowest divider receives a second write mid-frame, with a new clock select, new data and the mode bits set. The frame must keep its original period and data while the mode bits still update.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int REG_W   = 32;
    localparam int DATA_W  = 16;
    localparam int ADR5_W  = 5;
    localparam int HALF_W  = 5;
    localparam int FRAME_W = 64;
    localparam int PRE_LEN = 32;
    // bit index inside the 64-bit frame where the turnaround and data begin
    localparam int TA_POS  = 46;
    localparam int DAT_POS = 48;

    // control register bit positions
    localparam int B_MODE  = 30;
    localparam int B_PR    = 29;
    localparam int B_APOLL = 28;
    localparam int B_BUSY  = 27;
    localparam int B_SELHI = 26;
    localparam int B_SELLO = 24;
    localparam int B_GO    = 23;
    localparam int B_NOPRE = 22;
    localparam int B_RNW   = 21;
    localparam int B_ADRHI = 20;
    localparam int B_ADRLO = 16;

    typedef struct packed {
        logic              mode;
        logic              pr;
        logic              apoll;
        logic [2:0]        sel;
        logic              nopre;
        logic              rnw;
        logic [ADR5_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } ctrl_t;

    typedef struct packed {
        logic              rnw;
        logic              nopre;
        logic [ADR5_W-1:0] phy;
        logic [ADR5_W-1:0] regad;
        logic [DATA_W-1:0] data;
        logic [HALF_W-1:0] half;
    } frame_req_t;

    // half of the MDC period, in reference clocks
    function automatic logic [HALF_W-1:0] half_period(input logic [2:0] sel);
        case (sel)
            3'd0:    return 5'd2;
            3'd1:    return 5'd3;
            3'd2:    return 5'd4;
            3'd3:    return 5'd5;
            3'd4:    return 5'd7;
            3'd5:    return 5'd10;
            3'd6:    return 5'd12;
            default: return 5'd14;
        endcase
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.mode  = w[B_MODE];
        c.pr    = w[B_PR];
        c.apoll = w[B_APOLL];
        c.sel   = w[B_SELHI:B_SELLO];
        c.nopre = w[B_NOPRE];
        c.rnw   = w[B_RNW];
        c.regad = w[B_ADRHI:B_ADRLO];
        c.data  = w[DATA_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt;

    assign tick = run && (cnt == half - 5'd1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 5'd1;
    end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  frame_req_t        req,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int IDX_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   idx;
    logic               ph;
    logic               active;
    logic               rnw_q;
    logic [HALF_W-1:0]  half_q;
    logic [DATA_W-1:0]  shreg;
    logic               tick;

    mdio_clkgen u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .half (half_q),
        .tick (tick)
    );

    assign done    = active && tick && ph && (idx == IDX_W'(FRAME_W - 1));
    assign busy    = active;
    assign mdc     = ph;
    assign rd_data = shreg;
    assign mdio_o  = active ? frame[IDX_W'(FRAME_W - 1) - idx] : 1'b1;
    assign mdio_oe = active && !(rnw_q && idx >= IDX_W'(TA_POS));

    always_ff @(posedge clk) begin
        if (rst) begin
            frame  <= '0;
            idx    <= '0;
            ph     <= 1'b0;
            active <= 1'b0;
            rnw_q  <= 1'b0;
            half_q <= 5'd2;
            shreg  <= '0;
        end else if (!active) begin
            if (launch) begin
                frame  <= {{PRE_LEN{1'b1}}, 2'b01,
                           req.rnw ? 2'b10 : 2'b01,
                           req.phy, req.regad,
                           req.rnw ? 2'b11 : 2'b10,
                           req.rnw ? {DATA_W{1'b1}} : req.data};
                idx    <= req.nopre ? IDX_W'(PRE_LEN) : '0;
                ph     <= 1'b0;
                active <= 1'b1;
                rnw_q  <= req.rnw;
                half_q <= req.half;
            end
        end else if (tick) begin
            if (!ph) begin
                ph <= 1'b1;
                if (rnw_q && idx >= IDX_W'(DAT_POS))
                    shreg <= {shreg[DATA_W-2:0], mdio_i};
            end else begin
                ph <= 1'b0;
                if (idx == IDX_W'(FRAME_W - 1))
                    active <= 1'b0;
                else
                    idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 16'h1414,
    parameter logic [ADDR_W-1:0] PHY_OFF  = 16'h1418
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              launch,
    output frame_req_t        req,
    output logic [2:0]        cur_sel
);
    ctrl_t             ctrl;
    ctrl_t             wr_c;
    logic [ADR5_W-1:0] phy;
    logic              ctrl_wr;
    logic              phy_wr;

    assign wr_c    = unpack_ctrl(bus_wdata);
    assign ctrl_wr = bus_sel && bus_we && (bus_addr == CTRL_OFF);
    assign phy_wr  = bus_sel && bus_we && (bus_addr == PHY_OFF);
    assign launch  = ctrl_wr && !busy && bus_wdata[B_GO];
    assign cur_sel = ctrl.sel;

    always_comb begin
        req.rnw   = wr_c.rnw;
        req.nopre = wr_c.nopre;
        req.phy   = phy;
        req.regad = wr_c.regad;
        req.data  = wr_c.data;
        req.half  = half_period(wr_c.sel);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFF) begin
            bus_rdata[B_MODE]          = ctrl.mode;
            bus_rdata[B_PR]            = ctrl.pr;
            bus_rdata[B_APOLL]         = ctrl.apoll;
            bus_rdata[B_BUSY]          = busy;
            bus_rdata[B_SELHI:B_SELLO] = ctrl.sel;
            bus_rdata[B_GO]            = busy;
            bus_rdata[B_NOPRE]         = ctrl.nopre;
            bus_rdata[B_RNW]           = ctrl.rnw;
            bus_rdata[B_ADRHI:B_ADRLO] = ctrl.regad;
            bus_rdata[DATA_W-1:0]      = ctrl.data;
        end else if (bus_addr == PHY_OFF) begin
            bus_rdata[B_ADRHI:B_ADRLO] = phy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            phy  <= '0;
        end else begin
            if (phy_wr)
                phy <= bus_wdata[B_ADRHI:B_ADRLO];
            if (ctrl_wr) begin
                ctrl.mode  <= wr_c.mode;
                ctrl.pr    <= wr_c.pr;
                ctrl.apoll <= wr_c.apoll;
                if (!busy) begin
                    ctrl.sel   <= wr_c.sel;
                    ctrl.nopre <= wr_c.nopre;
                    ctrl.rnw   <= wr_c.rnw;
                    ctrl.regad <= wr_c.regad;
                    ctrl.data  <= wr_c.data;
                end
            end
            if (done && ctrl.rnw)
                ctrl.data <= rd_data;
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 16'h1414,
    parameter logic [ADDR_W-1:0] PHY_OFF  = 16'h1418
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    frame_req_t        req;
    logic              launch;
    logic              seq_busy;
    logic              seq_done;
    logic [DATA_W-1:0] rd_data;
    logic [2:0]        cur_sel;

    mdio_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFF (CTRL_OFF),
        .PHY_OFF  (PHY_OFF)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (seq_busy),
        .done      (seq_done),
        .rd_data   (rd_data),
        .launch    (launch),
        .req       (req),
        .cur_sel   (cur_sel)
    );

    mdio_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .req     (req),
        .mdio_i  (mdio_i),
        .busy    (seq_busy),
        .done    (seq_done),
        .rd_data (rd_data),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       busy,
    input logic       launch,
    input logic [2:0] sel
);
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc); // R4

    AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe); // R7

    AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o)); // R5

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy); // R3

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sel)); // R8

    AST_END_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !mdc); // R3
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (seq_busy),
    .launch  (launch),
    .sel     (cur_sel)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
    localparam logic [15:0] CTRL = 16'h1414;
    localparam logic [15:0] PHYR = 16'h1418;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;
    logic [1:0]  exq[$];
    int          bitpos = 0;
    logic [15:0] phy_val = '0;
    int          cyc = 0, last_rise = 0, last_period = 0, last_high = 0;
    logic        pm = 1'b0;

    always #5 clk = ~clk;

    assign mdio_i = (bitpos >= 48 && bitpos <= 63) ? phy_val[63 - bitpos] : 1'b1;

    mdio_mgmt_master u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected {oe,bit} per rising MDC edge
    always @(negedge clk) begin
        logic [1:0] e;
        cyc++;
        if (!rst && mdc && !pm) begin
            last_period = cyc - last_rise;
            last_rise = cyc;
            if (exq.size() == 0) begin
                check(1'b0, "R5 or R6 extra MDC edge", 32'(bitpos), 32'd0);
            end else begin
                e = exq.pop_front();
                check(e[1] === mdio_oe && (!e[1] || e[0] === mdio_o),
                      "R5 or R7 frame bit", {30'd0, mdio_oe, mdio_o}, {30'd0, e});
            end
        end
        if (!rst && !mdc && pm) begin
            last_high = cyc - last_rise;
            bitpos++;
        end
        pm = mdc;
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic push_frame(input bit rnw, input bit nopre, input logic [4:0] phy,
                              input logic [4:0] ra, input logic [15:0] d);
        if (!nopre) repeat (32) exq.push_back(2'b11);
        exq.push_back(2'b10); exq.push_back(2'b11);
        exq.push_back(rnw ? 2'b11 : 2'b10);
        exq.push_back(rnw ? 2'b10 : 2'b11);
        for (int i = 4; i >= 0; i--) exq.push_back({1'b1, phy[i]});
        for (int i = 4; i >= 0; i--) exq.push_back({1'b1, ra[i]});
        if (rnw) begin
            exq.push_back(2'b00); exq.push_back(2'b00);
            repeat (16) exq.push_back(2'b00);
        end else begin
            exq.push_back(2'b11); exq.push_back(2'b10);
            for (int i = 15; i >= 0; i--) exq.push_back({1'b1, d[i]});
        end
    endtask

    task automatic run_frame(input bit rnw, input bit nopre, input logic [2:0] sel,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] d, input logic [15:0] pv,
                             input int div, input bit poke);
        logic [31:0] v;
        int n;
        bitpos = nopre ? 32 : 0;
        phy_val = pv;
        push_frame(rnw, nopre, phy, ra, d);
        wr(CTRL, {5'b0, sel, 1'b1, nopre, rnw, ra, d});
        rd(CTRL, v);
        check(v[27] && v[23], "R3 go and busy set", {30'd0, v[27], v[23]}, 32'd3);
        if (poke) begin
            wr(CTRL, 32'h7080_FFFF);
            rd(CTRL, v);
            check(v[30:28] == 3'b111, "R8 mode bits update while busy", 32'(v[30:28]), 32'd7);
            check(v[26:24] == sel, "R8 clock select kept", 32'(v[26:24]), 32'(sel));
        end
        n = 0;
        do begin
            rd(CTRL, v);
            n++;
        end while ((v[27] || v[23]) && n < 5000);
        check(!v[27] && !v[23], "R3 go and busy clear", {30'd0, v[27], v[23]}, 32'd0);
        check(exq.size() == 0, nopre ? "R6 frame length" : "R5 frame length",
              32'(exq.size()), 32'd0);
        check(last_period == div, "R4 MDC period", 32'(last_period), 32'(div));
        check(last_high == div / 2, "R4 MDC high time", 32'(last_high), 32'(div / 2));
        check(v[15:0] == (rnw ? pv : d), rnw ? "R7 read data" : "R8 data kept",
              32'(v[15:0]), 32'(rnw ? pv : d));
        exq.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R1 pins idle", {30'd0, mdc, mdio_oe}, 32'd0);
        rd(CTRL, v); check(v == 32'd0, "R1 control reset", v, 32'd0);
        rd(PHYR, v); check(v == 32'd0, "R1 phy reg reset", v, 32'd0);
        // R2 phy register and unmapped offsets
        wr(PHYR, 32'hFFFF_FFFF);
        rd(PHYR, v); check(v == 32'h001F_0000, "R2 phy field only", v, 32'h001F_0000);
        rd(16'h1410, v); check(v == 32'd0, "R2 unmapped offset", v, 32'd0);
        rd(16'h141C, v); check(v == 32'd0, "R2 unmapped offset", v, 32'd0);
        wr(PHYR, 32'h0015_0000);
        // write with preamble, fastest divider
        run_frame(1'b0, 1'b0, 3'd0, 5'h15, 5'h03, 16'hA5C3, 16'h0000, 4, 1'b0);
        // read with preamble, middle divider
        wr(PHYR, 32'h000A_0000);
        run_frame(1'b1, 1'b0, 3'd3, 5'h0A, 5'h1E, 16'h0000, 16'h6C39, 10, 1'b0);
        // read without preamble (R6)
        run_frame(1'b1, 1'b1, 3'd0, 5'h0A, 5'h01, 16'h0000, 16'h8001, 4, 1'b0);
        // write without preamble, slowest divider, mid-frame write (R8)
        wr(PHYR, 32'h0013_0000);
        run_frame(1'b0, 1'b1, 3'd7, 5'h13, 5'h11, 16'h3C5A, 16'h0000, 28, 1'b1);
        rd(CTRL, v);
        check(v[30:28] == 3'b111, "R8 mode bits retained", 32'(v[30:28]), 32'd7);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R4 idle after frames", {30'd0, mdc, mdio_oe}, 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule